// File: doc/BRIEF.md
# Test Access Port Controller with Two-Bit Instruction Decoder

This block is the test access port of a chip's boundary-scan logic. It follows the standard sixteen-state test controller, which is clocked by the test clock and steered by the mode-select input. It holds a two-bit instruction and routes the serial test data through one data path, picked by the instruction. Four instructions exist: drive the pins from the boundary chain, snapshot or preload the boundary chain, read an identification word, and bypass the part through a single stage.

The boundary cells are not inside this block. They sit on a serial loop. The block sends test data in on `bsrSerOut`, takes the chain's last cell back on `bsrSerIn`, and drives capture, shift and update strobes to the cells. A mode output tells the pin cells when they must drive the pins. The serial output changes on the falling test clock edge. Its enable is high only while a shift is in progress.

Top module: `scanPortCtl`

## Requirements
- R1: While `trstN` is low, the controller is held in TEST-LOGIC-RESET, the active instruction is IDCODE and `tdoEn` is low.
- R2: Five rising TCK edges with TMS high bring the controller to TEST-LOGIC-RESET from any state. Each rising edge spent in that state makes IDCODE the active instruction.
- R3: State changes follow the standard sixteen-state graph, with TMS sampled on the rising TCK edge. This includes the PAUSE and EXIT2 loop that resumes a shift.
- R4: CAPTURE-IR loads the pattern 01 (bit 0 = 1) into the instruction shift stage. In SHIFT-IR, bit 0 leaves on TDO first and TDI enters at bit 1.
- R5: A new instruction takes effect only on the rising edge that leaves UPDATE-IR. While instruction bits are shifted, the selects keep the previous instruction.
- R6: Opcodes are 00 EXTEST, 01 SAMPLE/PRELOAD, 10 IDCODE and 11 BYPASS. Exactly one of the four select outputs is high.
- R7: Under BYPASS, CAPTURE-DR loads 0 into the single bypass stage. In SHIFT-DR, TDO repeats TDI one TCK later.
- R8: Under IDCODE, CAPTURE-DR loads the 32-bit `ID_VALUE`, and SHIFT-DR sends it out on TDO, bit 0 first.
- R9: Under EXTEST or SAMPLE/PRELOAD, TDO in SHIFT-DR carries `bsrSerIn`, `bsrCapture` is high in CAPTURE-DR and `bsrShift` is high in SHIFT-DR. `bsrSerOut` always equals TDI.
- R10: `bsrUpdate` is high in UPDATE-DR only under EXTEST. `extestMode` is high exactly while EXTEST is the active instruction.
- R11: TDO and `tdoEn` change on the falling TCK edge. `tdoEn` is high only in SHIFT-IR or SHIFT-DR, and TDO is 0 whenever `tdoEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdoEn | output | 1 | Output enable for TDO |
| bsrSerIn | input | 1 | Serial return from the last boundary cell |
| bsrSerOut | output | 1 | Serial data into the first boundary cell |
| bsrCapture | output | 1 | Boundary cells capture their inputs |
| bsrShift | output | 1 | Boundary cells shift one place |
| bsrUpdate | output | 1 | Boundary output latches load from the chain |
| extestMode | output | 1 | Pin cells drive the pins from their latches |
| selExtest | output | 1 | EXTEST active |
| selSample | output | 1 | SAMPLE/PRELOAD active |
| selIdcode | output | 1 | IDCODE active |
| selBypass | output | 1 | BYPASS active |

## Verification
The embedded properties are checked on every rising edge. They cover these invariants:
- The controller reaches reset after any run of five high TMS samples.
- CAPTURE-DR is entered from SELECT-DR.
- The strobes are mutually exclusive, and exactly one select is high.
- The instruction stays stable outside UPDATE-IR and reset.
- The capture values (01 for the instruction, 0 for bypass, the identification word) are present one edge after capture.
- `tdoEn` tracks the shift states.

Only the bench scenarios can show that the serial data is correct: the one-cycle bypass delay, the bit order of the identification word and of the instruction, and the pass-through of the boundary return. The same holds for the exact cycle in which a new opcode takes effect, and for reset taking over in the middle of a shift.

// File: rtl/scanPkg.sv
package scanPkg;

  localparam int IR_LEN = 2;

  localparam logic [IR_LEN-1:0] OP_EXTEST = 2'b00;
  localparam logic [IR_LEN-1:0] OP_SAMPLE = 2'b01;
  localparam logic [IR_LEN-1:0] OP_IDCODE = 2'b10;
  localparam logic [IR_LEN-1:0] OP_BYPASS = 2'b11;
  localparam logic [IR_LEN-1:0] IR_CAPTURE_PAT = 2'b01;

  typedef enum logic [3:0] {
    stReset, stIdle,
    stSelDr, stCapDr, stShfDr, stEx1Dr, stPauDr, stEx2Dr, stUpdDr,
    stSelIr, stCapIr, stShfIr, stEx1Ir, stPauIr, stEx2Ir, stUpdIr
  } tapState_e;

  typedef struct packed {
    logic inReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapStrobe_t;

endpackage

// File: rtl/tapFsm.sv
module tapFsm
  import scanPkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  output tapState_e  state,
  output tapStrobe_t strb
);

  localparam int RESET_RUN = 5;
  localparam int RUN_W = $clog2(RESET_RUN + 1);

  tapState_e nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      stReset: nextState = tms ? stReset : stIdle;
      stIdle:  nextState = tms ? stSelDr : stIdle;
      stSelDr: nextState = tms ? stSelIr : stCapDr;
      stCapDr: nextState = tms ? stEx1Dr : stShfDr;
      stShfDr: nextState = tms ? stEx1Dr : stShfDr;
      stEx1Dr: nextState = tms ? stUpdDr : stPauDr;
      stPauDr: nextState = tms ? stEx2Dr : stPauDr;
      stEx2Dr: nextState = tms ? stUpdDr : stShfDr;
      stUpdDr: nextState = tms ? stSelDr : stIdle;
      stSelIr: nextState = tms ? stReset : stCapIr;
      stCapIr: nextState = tms ? stEx1Ir : stShfIr;
      stShfIr: nextState = tms ? stEx1Ir : stShfIr;
      stEx1Ir: nextState = tms ? stUpdIr : stPauIr;
      stPauIr: nextState = tms ? stEx2Ir : stPauIr;
      stEx2Ir: nextState = tms ? stUpdIr : stShfIr;
      stUpdIr: nextState = tms ? stSelDr : stIdle;
      default: nextState = stReset;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= stReset;
    else        state <= nextState;
  end

  always_comb begin
    strb.inReset   = (state == stReset);
    strb.captureIr = (state == stCapIr);
    strb.shiftIr   = (state == stShfIr);
    strb.updateIr  = (state == stUpdIr);
    strb.captureDr = (state == stCapDr);
    strb.shiftDr   = (state == stShfDr);
    strb.updateDr  = (state == stUpdDr);
  end

  // Run length of consecutive high TMS samples, saturating; used by the guard below.
  logic [RUN_W-1:0] tmsRun;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                       tmsRun <= '0;
    else if (!tms)                    tmsRun <= '0;
    else if (tmsRun != RUN_W'(RESET_RUN)) tmsRun <= tmsRun + 1'b1;
  end

  a_r2_five_high_resets: assert property (@(posedge tck) disable iff (!trstN)
    (tmsRun == RUN_W'(RESET_RUN)) |-> (state == stReset));

  a_r3_select_to_capture: assert property (@(posedge tck) disable iff (!trstN)
    (state == stSelDr && !tms) |=> (state == stCapDr));

  a_r3_strobes_exclusive: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0(strb));

endmodule

// File: rtl/tapRegs.sv
module tapRegs
  import scanPkg::*;
#(
  parameter int                  ID_WIDTH = 32,
  parameter logic [ID_WIDTH-1:0] ID_VALUE = 32'h0A5C_3E01
) (
  input  logic       tck,
  input  logic       trstN,
  input  logic       tdi,
  input  logic       bsrSerIn,
  input  tapStrobe_t strb,
  output logic       tdo,
  output logic       tdoEn,
  output logic       bsrCapture,
  output logic       bsrShift,
  output logic       bsrUpdate,
  output logic       extestMode,
  output logic       selExtest,
  output logic       selSample,
  output logic       selIdcode,
  output logic       selBypass
);

  logic [IR_LEN-1:0]   irShift;
  logic [IR_LEN-1:0]   irReg;
  logic                bypassBit;
  logic [ID_WIDTH-1:0] idShift;
  logic                bsrPath;
  logic                drBit;
  logic                tdoNext;

  // Instruction decode
  always_comb begin
    selExtest = (irReg == OP_EXTEST);
    selSample = (irReg == OP_SAMPLE);
    selIdcode = (irReg == OP_IDCODE);
    selBypass = (irReg == OP_BYPASS);
  end

  assign bsrPath = selExtest | selSample;

  // Instruction shift stage and active instruction
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE_PAT;
      irReg   <= OP_IDCODE;
    end else begin
      if (strb.captureIr)    irShift <= IR_CAPTURE_PAT;
      else if (strb.shiftIr) irShift <= {tdi, irShift[IR_LEN-1:1]};
      if (strb.inReset)       irReg <= OP_IDCODE;
      else if (strb.updateIr) irReg <= irShift;
    end
  end

  // Single-stage bypass
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                            bypassBit <= 1'b0;
    else if (strb.captureDr && selBypass)  bypassBit <= 1'b0;
    else if (strb.shiftDr && selBypass)    bypassBit <= tdi;
  end

  // Identification word
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                            idShift <= ID_VALUE;
    else if (strb.captureDr && selIdcode)  idShift <= ID_VALUE;
    else if (strb.shiftDr && selIdcode)    idShift <= {tdi, idShift[ID_WIDTH-1:1]};
  end

  // Output path, retimed to the falling edge
  always_comb begin
    if (bsrPath)        drBit = bsrSerIn;
    else if (selBypass) drBit = bypassBit;
    else                drBit = idShift[0];
    if (strb.shiftIr)      tdoNext = irShift[0];
    else if (strb.shiftDr) tdoNext = drBit;
    else                   tdoNext = 1'b0;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= tdoNext;
      tdoEn <= strb.shiftIr | strb.shiftDr;
    end
  end

  // Boundary chain strobes
  assign bsrCapture = strb.captureDr & bsrPath;
  assign bsrShift   = strb.shiftDr & bsrPath;
  assign bsrUpdate  = strb.updateDr & selExtest;
  assign extestMode = selExtest;

  a_r6_one_select: assert property (@(posedge tck) disable iff (!trstN)
    $onehot({selExtest, selSample, selIdcode, selBypass}));

  a_r4_ir_capture: assert property (@(posedge tck) disable iff (!trstN)
    strb.captureIr |=> (irShift == IR_CAPTURE_PAT));

  a_r5_ir_holds: assert property (@(posedge tck) disable iff (!trstN)
    (!strb.updateIr && !strb.inReset) |=> $stable(irReg));

  a_r7_bypass_zero: assert property (@(posedge tck) disable iff (!trstN)
    (strb.captureDr && selBypass) |=> !bypassBit);

  a_r8_id_capture: assert property (@(posedge tck) disable iff (!trstN)
    (strb.captureDr && selIdcode) |=> (idShift == ID_VALUE));

  a_r11_enable_tracks_shift: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn == (strb.shiftIr || strb.shiftDr));

endmodule

// File: rtl/scanPortCtl.sv
module scanPortCtl
  import scanPkg::*;
#(
  parameter int                  ID_WIDTH = 32,
  parameter logic [ID_WIDTH-1:0] ID_VALUE = 32'h0A5C_3E01
) (
  input  logic tck,
  input  logic trstN,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdoEn,
  input  logic bsrSerIn,
  output logic bsrSerOut,
  output logic bsrCapture,
  output logic bsrShift,
  output logic bsrUpdate,
  output logic extestMode,
  output logic selExtest,
  output logic selSample,
  output logic selIdcode,
  output logic selBypass
);

  tapState_e  state;
  tapStrobe_t strb;

  tapFsm u_fsm (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .state (state),
    .strb  (strb)
  );

  tapRegs #(
    .ID_WIDTH (ID_WIDTH),
    .ID_VALUE (ID_VALUE)
  ) u_regs (
    .tck        (tck),
    .trstN      (trstN),
    .tdi        (tdi),
    .bsrSerIn   (bsrSerIn),
    .strb       (strb),
    .tdo        (tdo),
    .tdoEn      (tdoEn),
    .bsrCapture (bsrCapture),
    .bsrShift   (bsrShift),
    .bsrUpdate  (bsrUpdate),
    .extestMode (extestMode),
    .selExtest  (selExtest),
    .selSample  (selSample),
    .selIdcode  (selIdcode),
    .selBypass  (selBypass)
  );

  assign bsrSerOut = tdi;

  a_r1_reset_idle: assert property (@(posedge tck) disable iff (!trstN)
    (state == stReset) |-> !tdoEn);

endmodule

// File: tb/test_scanPortCtl.sv
module test_scanPortCtl;

  localparam logic [31:0] ID_WORD = 32'h1B3C_5A97;

  localparam int S_TLR = 0,  S_RTI = 1,
                 S_SDR = 2,  S_CDR = 3,  S_HDR = 4,  S_E1D = 5,  S_PDR = 6,  S_E2D = 7,  S_UDR = 8,
                 S_SIR = 9,  S_CIR = 10, S_HIR = 11, S_E1I = 12, S_PIR = 13, S_E2I = 14, S_UIR = 15;

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic bsrSerIn = 1'b0;
  logic tdo, tdoEn, bsrSerOut, bsrCapture, bsrShift, bsrUpdate, extestMode;
  logic selExtest, selSample, selIdcode, selBypass;

  int compared = 0;
  int mismatched = 0;

  // reference model state
  int       mState;
  bit [1:0] mIr;
  bit       irQ[$];
  bit       drQ[$];
  bit       mTdo, mEn;

  always #10 tck = ~tck;

  scanPortCtl #(.ID_WIDTH(32), .ID_VALUE(ID_WORD)) i_scanPortCtl (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .bsrSerIn(bsrSerIn), .bsrSerOut(bsrSerOut), .bsrCapture(bsrCapture),
    .bsrShift(bsrShift), .bsrUpdate(bsrUpdate), .extestMode(extestMode),
    .selExtest(selExtest), .selSample(selSample), .selIdcode(selIdcode),
    .selBypass(selBypass)
  );

  // R3: standard controller graph
  function automatic int nextOf(input int s, input bit m);
    case (s)
      S_TLR: return m ? S_TLR : S_RTI;
      S_RTI: return m ? S_SDR : S_RTI;
      S_SDR: return m ? S_SIR : S_CDR;
      S_CDR: return m ? S_E1D : S_HDR;
      S_HDR: return m ? S_E1D : S_HDR;
      S_E1D: return m ? S_UDR : S_PDR;
      S_PDR: return m ? S_E2D : S_PDR;
      S_E2D: return m ? S_UDR : S_HDR;
      S_UDR: return m ? S_SDR : S_RTI;
      S_SIR: return m ? S_TLR : S_CIR;
      S_CIR: return m ? S_E1I : S_HIR;
      S_HIR: return m ? S_E1I : S_HIR;
      S_E1I: return m ? S_UIR : S_PIR;
      S_PIR: return m ? S_E2I : S_PIR;
      S_E2I: return m ? S_UIR : S_HIR;
      default: return m ? S_SDR : S_RTI;
    endcase
  endfunction

  task automatic modelReset();
    mState = S_TLR; mIr = 2'b10; mTdo = 0; mEn = 0;
    irQ = '{1'b1, 1'b0}; drQ.delete();
  endtask

  task automatic modelRise(input bit m, input bit d);
    case (mState)
      S_TLR: mIr = 2'b10;
      S_CIR: irQ = '{1'b1, 1'b0};
      S_HIR: begin void'(irQ.pop_front()); irQ.push_back(d); end
      S_UIR: mIr = {irQ[1], irQ[0]};
      S_CDR: begin
        drQ.delete();
        if (mIr == 2'b11) drQ.push_back(1'b0);
        else if (mIr == 2'b10) for (int k = 0; k < 32; k++) drQ.push_back(ID_WORD[k]);
      end
      S_HDR: if (drQ.size() > 0) begin void'(drQ.pop_front()); drQ.push_back(d); end
      default: ;
    endcase
    mState = nextOf(mState, m);
  endtask

  task automatic modelFall();
    mEn = (mState == S_HIR) || (mState == S_HDR);
    if (mState == S_HIR) mTdo = irQ[0];
    else if (mState == S_HDR) mTdo = (mIr[1] == 1'b0) ? bsrSerIn : drQ[0];
    else mTdo = 1'b0;
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    string tTag;
    bit bsrIns;
    bsrIns = (mIr[1] == 1'b0);
    if (mState == S_HIR) tTag = "R4";
    else if (mState == S_HDR) tTag = (mIr == 2'b11) ? "R7" : (mIr == 2'b10) ? "R8" : "R9";
    else tTag = "R11";
    chk(tdo === mTdo, tTag, "tdo", tdo, mTdo);
    chk(tdoEn === mEn, "R11", "tdoEn", tdoEn, mEn);
    chk(selExtest === (mIr == 2'b00), "R5", "selExtest", selExtest, mIr == 2'b00);
    chk(selSample === (mIr == 2'b01), "R5", "selSample", selSample, mIr == 2'b01);
    chk(selIdcode === (mIr == 2'b10), "R6", "selIdcode", selIdcode, mIr == 2'b10);
    chk(selBypass === (mIr == 2'b11), "R6", "selBypass", selBypass, mIr == 2'b11);
    chk(extestMode === (mIr == 2'b00), "R10", "extestMode", extestMode, mIr == 2'b00);
    chk(bsrUpdate === (mState == S_UDR && mIr == 2'b00), "R10", "bsrUpdate", bsrUpdate,
        mState == S_UDR && mIr == 2'b00);
    chk(bsrCapture === (mState == S_CDR && bsrIns), "R9", "bsrCapture", bsrCapture,
        mState == S_CDR && bsrIns);
    chk(bsrShift === (mState == S_HDR && bsrIns), "R9", "bsrShift", bsrShift,
        mState == S_HDR && bsrIns);
    chk(bsrSerOut === tdi, "R9", "bsrSerOut", bsrSerOut, tdi);
  endtask

  // drive at falling edge + 5 ns, model on the rising edge, compare at the next falling edge + 5 ns
  task automatic step(input bit m, input bit d, input bit ser = 1'b0);
    tms = m; tdi = d; bsrSerIn = ser;
    @(posedge tck);
    modelRise(m, d);
    @(negedge tck); #5;
    modelFall();
    compareAll();
  endtask

  task automatic doReset();
    trstN = 1'b0; tms = 1'b1;
    repeat (2) @(negedge tck);
    #5;
    modelReset();
    compareAll();
    chk(tdoEn === 1'b0 && selIdcode === 1'b1, "R1", "reset tdoEn/selIdcode",
        {tdoEn, selIdcode}, 2'b01);
    trstN = 1'b1;
  endtask

  // from Run-Test/Idle, shift a two-bit opcode and return to Run-Test/Idle
  task automatic loadIr(input bit [1:0] op);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    step(0, op[0]);
    step(1, op[1]);
    step(1, 0);
    step(0, 0);
  endtask

  // from Run-Test/Idle, shift n data bits, optionally pausing halfway
  task automatic scanDr(input int n, input bit [31:0] pat, input bit [31:0] ser, input bit withPause);
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < n; k++) begin
      step(k == n - 1, pat[k], ser[k]);
      if (withPause && k == n / 2 - 1 && k != n - 1) begin
        step(1, 0); step(0, 0); step(0, 0); step(1, 0); step(0, 0);
        chk(tdoEn === 1'b1, "R3", "tdoEn after pause resume", tdoEn, 1);
      end
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #4_000_000;
    mismatched++;
    $display("FAIL R3 watchdog actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge tck); #5;
    doReset();
    step(0, 0);
    scanDr(32, 32'hFFFF_0000, 32'h0, 1'b0);          // R8 identification word
    scanDr(8, 32'h0000_00A5, 32'h0, 1'b1);           // R8 with pause loop
    loadIr(2'b11);                                   // R5 R6 bypass load
    scanDr(10, 32'h0000_02D3, 32'h0, 1'b1);          // R7 one-stage delay
    loadIr(2'b00);                                   // R10 extest
    scanDr(6, 32'h0000_0015, 32'h0000_002C, 1'b0);   // R9 chain return
    loadIr(2'b01);                                   // sample/preload
    scanDr(5, 32'h0000_0009, 32'h0000_0017, 1'b1);
    loadIr(2'b10);                                   // explicit IDCODE
    scanDr(4, 32'h0000_000F, 32'h0, 1'b0);
    // R2 from PAUSE-DR under BYPASS
    loadIr(2'b11);
    step(1, 0); step(0, 0); step(0, 1); step(1, 0); step(0, 0);
    for (int k = 0; k < 6; k++) step(1, 0);
    chk(selIdcode === 1'b1, "R2", "selIdcode after TMS-high run", selIdcode, 1);
    // R2 from SHIFT-IR mid-shift (update of 00 on the way out)
    step(0, 0);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 6; k++) step(1, 0);
    chk(selIdcode === 1'b1, "R2", "selIdcode after exit from SHIFT-IR", selIdcode, 1);
    // R1 asynchronous reset during a data shift
    step(0, 0);
    loadIr(2'b11);
    step(1, 0); step(0, 0); step(0, 1); step(0, 1);
    doReset();
    step(0, 0);
    scanDr(3, 32'h5, 32'h0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule